// File: doc/BRIEF.md
# Parallel Flash Program/Erase Sequencer

This block runs one flash operation at a time on behalf of a host and drives an 8-bit parallel NOR flash through its command protocol. A request enters through a valid/ready front end and selects one of four operations: identify, return to array-read mode, program one byte, or erase one block. The sequencer issues the flash write and read bus cycles the operation needs. For program and erase it polls the device status until the ready bit rises or a poll budget runs out. It then decodes the error bits for that operation and clears the device status, polling ready a second time. Finally it puts the device back into array-read mode and reports a 3-bit result code together with a one-cycle done pulse.

The front end accepts a request only while `req_ready` is high. After a request is accepted, `req_ready` stays low until the operation ends. It rises in the same cycle as `done`, so the host must hold any further request until then. The flash port is a plain synchronous strobe bus. `fl_we` writes `fl_wdata` to `fl_addr` in that cycle. `fl_re` starts a read, and `fl_rdata` carries the byte in the following cycle. A programmable stall, sampled when a request is accepted, spaces successive status polls apart.

Top module: `pflash_seq`

## Requirements
- R1: `req_ready` is high only while idle. It falls in the cycle after a request is accepted, and it rises again only in the cycle where `done` is high. `done` lasts exactly one cycle.
- R2: `req_op` encodes 0 = identify, 1 = read-array, 2 = program, 3 = erase. A read-array request writes 0xFF to `req_addr` and ends with result 0.
- R3: A program request writes, at `req_addr` and in this order: 0xFF, 0x40, the data byte, the status polls, 0x50, the second status polls, and finally 0xFF.
- R4: An erase request writes, at `req_addr` and in this order: 0x20, 0xD0, the status polls, 0x50, the second status polls, and finally 0xFF.
- R5: Each poll writes 0x70, and the next cycle is a read strobe. A poll phase ends on a status byte with bit 7 set, or after POLL_MAX reads. Successive status read strobes within a phase are 3 + stall cycles apart.
- R6: A program succeeds (result 0) only when status bits 4 and 3 are both clear.
- R7: An erase succeeds (result 0) only when status bits 5 and 3 are clear and bits 5:4 are not both set. Bit 4 alone does not fail an erase.
- R8: If bit 7 of the last status byte of the first poll phase is clear, the result is 2 (timeout), whatever the other bits hold.
- R9: A failure is coded by applying these steps in order to the status ANDed with the operation's mask (0x18 for program, 0x28 for erase), with each later match replacing the earlier one: start at 1 (unknown); 2 if the masked value is zero; 3 if bit 4 is set; 4 if bit 5 is set; 5 if bit 3 is set.
- R10: The result is fixed before the 0x50 clear. The second poll phase, even if it times out, does not change the result.
- R11: Identify aligns the address down to a 64 KiB boundary and writes 0x90 there. It reads offset 0 and then offset 1, and writes 0xFF at the aligned address. The result is 0 if the two bytes are 0x89 and 0xA2, and 6 otherwise.
- R12: `fl_we` and `fl_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted on valid |
| req_op | input | 2 | Operation select |
| req_addr | input | ADDR_W | Target byte address |
| req_wdata | input | 8 | Byte to program |
| stall_cycles | input | STALL_W | Idle cycles between polls, sampled on accept |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Result code, valid with done |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data, one cycle after fl_re |

## Verification
The hardest situations to reach are at the edges of the two poll phases. One is a device that reports ready on exactly the last allowed read, which must succeed, next to one that is busy for one more read, which must time out. The other is a clear phase that times out while the main result is an error, which must leave that result unchanged. A behavioural flash model in the bench counts down a configurable number of busy status reads for each phase. Directed runs place that count at POLL_MAX-1, at POLL_MAX and beyond it. Seeded random runs cover the error-bit patterns, stalls and operations.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  localparam logic [1:0] OP_IDENT = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_PROG  = 2'd2;
  localparam logic [1:0] OP_ERASE = 2'd3;

  localparam logic [2:0] RC_OK      = 3'd0;
  localparam logic [2:0] RC_UNKNOWN = 3'd1;
  localparam logic [2:0] RC_TIMEOUT = 3'd2;
  localparam logic [2:0] RC_WRERR   = 3'd3;
  localparam logic [2:0] RC_ERERR   = 3'd4;
  localparam logic [2:0] RC_VPPLOW  = 3'd5;
  localparam logic [2:0] RC_IDBAD   = 3'd6;

  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_PROG   = 8'h40;
  localparam logic [7:0] CMD_ESETUP = 8'h20;
  localparam logic [7:0] CMD_ECONF  = 8'hD0;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_CLR    = 8'h50;
  localparam logic [7:0] CMD_IDENT  = 8'h90;

  typedef enum logic [3:0] {
    S_IDLE, S_RA, S_C1, S_C2, S_PW, S_PR, S_PD, S_ST,
    S_CLR, S_FIN, S_IW, S_IR0, S_IR1, S_ID1
  } seq_state_e;
endpackage

// File: rtl/pflash_decode.sv
module pflash_decode
  import pflash_pkg::*;
(
  input  logic       is_erase,
  input  logic [7:0] status,
  output logic [2:0] code
);
  logic [7:0] mask, masked;
  logic       fail;
  logic [2:0] prio;

  always_comb begin
    mask   = is_erase ? 8'h28 : 8'h18;
    masked = status & mask;
    fail   = (masked != 8'h00) || (is_erase && (status[5:4] == 2'b11));
    prio   = RC_UNKNOWN;
    if (masked == 8'h00) prio = RC_TIMEOUT;
    if (masked[4])       prio = RC_WRERR;
    if (masked[5])       prio = RC_ERERR;
    if (masked[3])       prio = RC_VPPLOW;
    if (!status[7])      code = RC_TIMEOUT;
    else if (fail)       code = prio;
    else                 code = RC_OK;
  end

  always_comb begin
    a_ok_clean_r6: assert (!(status[7] && (status[5:3] == 3'b000)) || code == RC_OK);
  end
endmodule

// File: rtl/pflash_pacer.sv
module pflash_pacer #(
  parameter int POLL_MAX = 16,
  parameter int STALL_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic               poll_tick,
  input  logic               stall_load,
  input  logic               stall_step,
  input  logic [STALL_W-1:0] stall_len,
  output logic               last_poll,
  output logic               stall_zero
);
  localparam int CNT_W = $clog2(POLL_MAX + 1);

  logic [CNT_W-1:0]   poll_cnt;
  logic [STALL_W-1:0] st_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_cnt <= '0;
      st_cnt   <= '0;
    end else begin
      if (restart)        poll_cnt <= '0;
      else if (poll_tick) poll_cnt <= poll_cnt + 1'b1;
      if (stall_load)     st_cnt <= stall_len - 1'b1;
      else if (stall_step && st_cnt != '0) st_cnt <= st_cnt - 1'b1;
    end
  end

  assign last_poll  = (poll_cnt == CNT_W'(POLL_MAX - 1));
  assign stall_zero = (st_cnt == '0);

  p_budget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= CNT_W'(POLL_MAX));
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
  import pflash_pkg::*;
#(
  parameter int          ADDR_W   = 20,
  parameter int          BLK_W    = 16,
  parameter int          POLL_MAX = 16,
  parameter int          STALL_W  = 4,
  parameter logic [7:0]  MFR_ID   = 8'h89,
  parameter logic [7:0]  DEV_ID   = 8'hA2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [7:0]         req_wdata,
  input  logic [STALL_W-1:0] stall_cycles,
  output logic               done,
  output logic [2:0]         result,
  output logic               fl_we,
  output logic               fl_re,
  output logic [ADDR_W-1:0]  fl_addr,
  output logic [7:0]         fl_wdata,
  input  logic [7:0]         fl_rdata
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  seq_state_e         state;
  logic [1:0]         op_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [7:0]         data_q, id0_q;
  logic [STALL_W-1:0] stall_q;
  logic [2:0]         res_q, dec_code;
  logic               clr_phase, done_q;
  logic               last_poll, stall_zero, poll_end;
  logic               is_erase;

  assign is_erase = (op_q == OP_ERASE);
  assign poll_end = fl_rdata[7] || last_poll;

  pflash_decode u_dec (
    .is_erase (is_erase),
    .status   (fl_rdata),
    .code     (dec_code)
  );

  pflash_pacer #(.POLL_MAX(POLL_MAX), .STALL_W(STALL_W)) u_pace (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (state == S_C2 || state == S_CLR),
    .poll_tick  (state == S_PD),
    .stall_load (state == S_PD && !poll_end && stall_q != '0),
    .stall_step (state == S_ST),
    .stall_len  (stall_q),
    .last_poll  (last_poll),
    .stall_zero (stall_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_q    <= '0;
      id0_q     <= '0;
      stall_q   <= '0;
      res_q     <= RC_OK;
      clr_phase <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q      <= req_op;
          addr_q    <= (req_op == OP_IDENT) ?
                       {req_addr[ADDR_W-1:BLK_W], {BLK_W{1'b0}}} : req_addr;
          data_q    <= req_wdata;
          stall_q   <= stall_cycles;
          clr_phase <= 1'b0;
          case (req_op)
            OP_IDENT: state <= S_IW;
            OP_ERASE: state <= S_C1;
            default:  state <= S_RA;
          endcase
        end
        S_RA: if (op_q == OP_READ) begin
          res_q  <= RC_OK;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end else begin
          state <= S_C1;
        end
        S_C1: state <= S_C2;
        S_C2: state <= S_PW;
        S_PW: state <= S_PR;
        S_PR: state <= S_PD;
        S_PD: if (poll_end) begin
          if (!clr_phase) begin
            res_q <= dec_code;
            state <= S_CLR;
          end else begin
            state <= S_FIN;
          end
        end else if (stall_q == '0) begin
          state <= S_PW;
        end else begin
          state <= S_ST;
        end
        S_ST:  if (stall_zero) state <= S_PW;
        S_CLR: begin
          clr_phase <= 1'b1;
          state     <= S_PW;
        end
        S_FIN: begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_IW:  state <= S_IR0;
        S_IR0: state <= S_IR1;
        S_IR1: begin
          id0_q <= fl_rdata;
          state <= S_ID1;
        end
        S_ID1: begin
          res_q <= (id0_q == MFR_ID && fl_rdata == DEV_ID) ? RC_OK : RC_IDBAD;
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_we    = 1'b0;
    fl_wdata = 8'h00;
    case (state)
      S_RA, S_FIN: begin fl_we = 1'b1; fl_wdata = CMD_ARRAY; end
      S_C1:  begin fl_we = 1'b1; fl_wdata = is_erase ? CMD_ESETUP : CMD_PROG; end
      S_C2:  begin fl_we = 1'b1; fl_wdata = is_erase ? CMD_ECONF : data_q; end
      S_PW:  begin fl_we = 1'b1; fl_wdata = CMD_STAT; end
      S_CLR: begin fl_we = 1'b1; fl_wdata = CMD_CLR; end
      S_IW:  begin fl_we = 1'b1; fl_wdata = CMD_IDENT; end
      default: ;
    endcase
  end

  assign fl_re     = (state == S_PR) || (state == S_IR0) || (state == S_IR1);
  assign fl_addr   = (state == S_IR1) ? (addr_q | ONE) : addr_q;
  assign req_ready = (state == S_IDLE);
  assign done      = done_q;
  assign result    = res_q;

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_with_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> done);
  p_accept_drops_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_bus_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));
  p_stat_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && fl_wdata == CMD_STAT) |=> fl_re);
  p_clear_keeps_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_phase |-> $stable(res_q));
endmodule

// File: tb/sim_pflash_seq.sv
`timescale 1ns/1ps
module sim_pflash_seq;
  localparam int AW = 20;
  localparam int PM = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = 8'h00;
  logic [3:0] stall_cycles = 4'd0;
  logic done, fl_we, fl_re;
  logic [2:0] result;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;

  int vectors = 0, fails = 0;

  always #2.5 clk = ~clk;

  pflash_seq #(.ADDR_W(AW), .BLK_W(16), .POLL_MAX(PM), .STALL_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .stall_cycles(stall_cycles), .done(done), .result(result),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata));

  // behavioural flash
  int cfg_busy = 0, cfg_cbusy = 0, cfg_stall = 0;
  logic [7:0] cfg_err = 8'h00, cfg_mfr = 8'h89, cfg_dev = 8'hA2;
  logic clr_log = 1'b0;
  logic [7:0] w_dat [0:63];
  logic [AW-1:0] w_adr [0:63];
  int n_w, n_sr, gap_bad, coll, busy_left, cyc, last_re;
  logic lre_ok;
  logic [7:0] err_q, prev_w;
  logic [1:0] mode; // 0 array 1 status 2 id

  initial begin
    fl_rdata = 8'h00; n_w = 0; n_sr = 0; gap_bad = 0; coll = 0; busy_left = 0;
    cyc = 0; last_re = 0; lre_ok = 1'b0; err_q = 8'h00; prev_w = 8'h00; mode = 2'd0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr_log) begin
      n_w <= 0; n_sr <= 0; gap_bad <= 0; coll <= 0; lre_ok <= 1'b0;
    end else begin
      if (fl_we && fl_re) coll <= coll + 1;
      if (fl_we) begin
        if (n_w < 64) begin w_dat[n_w] <= fl_wdata; w_adr[n_w] <= fl_addr; end
        n_w <= n_w + 1;
        prev_w <= fl_wdata;
        if (fl_wdata != 8'h70) lre_ok <= 1'b0;
        if (prev_w == 8'h40 || (prev_w == 8'h20 && fl_wdata == 8'hD0)) begin
          busy_left <= cfg_busy; err_q <= cfg_err; mode <= 2'd1;
        end else if (fl_wdata == 8'h70) mode <= 2'd1;
        else if (fl_wdata == 8'h90) mode <= 2'd2;
        else if (fl_wdata == 8'hFF) mode <= 2'd0;
        else if (fl_wdata == 8'h50) begin
          err_q <= 8'h00; busy_left <= cfg_cbusy; mode <= 2'd1;
        end
      end
      if (fl_re) begin
        if (mode == 2'd1) begin
          fl_rdata <= {(busy_left == 0), err_q[6:0]};
          if (busy_left > 0) busy_left <= busy_left - 1;
          n_sr <= n_sr + 1;
          if (lre_ok && (cyc - last_re) != 3 + cfg_stall) gap_bad <= gap_bad + 1;
          last_re <= cyc; lre_ok <= 1'b1;
        end else if (mode == 2'd2) begin
          fl_rdata <= (fl_addr[15:1] != 15'd0) ? 8'h00 : (fl_addr[0] ? cfg_dev : cfg_mfr);
        end else fl_rdata <= 8'hFF;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int prio_code(input logic [7:0] m);
    int c = 1;
    if (m == 8'h00) c = 2;
    if (m[4]) c = 3;
    if (m[5]) c = 4;
    if (m[3]) c = 5;
    return c;
  endfunction

  function automatic int exp_code(input logic [1:0] op, input logic [7:0] e, input int busy);
    logic [7:0] m;
    if (busy + 1 > PM) return 2;            // R8
    if (op == 2'd2) begin                    // R6
      m = e & 8'h18;
      return (m == 8'h00) ? 0 : prio_code(m);
    end
    m = e & 8'h28;                           // R7
    return (m == 8'h00 && (e & 8'h30) != 8'h30) ? 0 : prio_code(m);
  endfunction

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [7:0] d,
                     input logic [7:0] e, input int busy, input int cbusy, input int st);
    int wait_c = 0;
    int r1, r2, pre, exp_res, bad;
    logic [AW-1:0] al;
    cfg_err = e; cfg_busy = busy; cfg_cbusy = cbusy; cfg_stall = st;
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
    chk("R1 idle ready", int'(req_ready), 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d; stall_cycles = 4'(st);
    @(negedge clk); req_valid = 1'b0;
    chk("R1 ready drops", int'(req_ready), 0);
    while (!done && wait_c < 3000) begin
      chk("R1 ready low while busy", int'(req_ready), 0);
      @(negedge clk); wait_c++;
    end
    if (!done) begin chk("watchdog op", 0, 1); return; end
    chk("R1 ready with done", int'(req_ready), 1);
    chk("R12 no we/re overlap", coll, 0);
    al = {a[AW-1:16], 16'h0000};
    case (op)
      2'd1: begin
        chk("R2 read-array writes", n_w, 1);
        chk("R2 read-array cmd", int'(w_dat[0]), 8'hFF);
        chk("R2 read-array addr", int'(w_adr[0]), int'(a));
        chk("R2 read-array result", int'(result), 0);
      end
      2'd0: begin
        chk("R11 identify writes", n_w, 2);
        chk("R11 identify cmd", int'(w_dat[0]), 8'h90);
        chk("R11 identify restore", int'(w_dat[1]), 8'hFF);
        chk("R11 identify addr", int'(w_adr[0]), int'(al));
        chk("R11 identify result", int'(result),
            (cfg_mfr == 8'h89 && cfg_dev == 8'hA2) ? 0 : 6);
      end
      default: begin
        r1 = (busy + 1 <= PM) ? busy + 1 : PM;
        r2 = (cbusy + 1 <= PM) ? cbusy + 1 : PM;
        pre = (op == 2'd2) ? 3 : 2;
        exp_res = exp_code(op, e, busy);
        chk("R5 status reads", n_sr, r1 + r2);
        chk("R5 poll spacing", gap_bad, 0);
        chk("R3/R4 write count", n_w, pre + r1 + 1 + r2 + 1);
        if (op == 2'd2) begin
          chk("R3 pre array", int'(w_dat[0]), 8'hFF);
          chk("R3 program cmd", int'(w_dat[1]), 8'h40);
          chk("R3 data byte", int'(w_dat[2]), int'(d));
        end else begin
          chk("R4 setup", int'(w_dat[0]), 8'h20);
          chk("R4 confirm", int'(w_dat[1]), 8'hD0);
        end
        chk("R5 first poll cmd", int'(w_dat[pre]), 8'h70);
        chk("R10 clear cmd", int'(w_dat[pre + r1]), 8'h50);
        chk("R3/R4 final array", int'(w_dat[pre + r1 + r2 + 1]), 8'hFF);
        bad = 0;
        for (int i = 0; i < n_w && i < 64; i++) if (w_adr[i] != a) bad++;
        chk("R3/R4 address", bad, 0);
        chk("R6/R7/R8/R9/R10 result", int'(result), exp_res);
      end
    endcase
    @(negedge clk);
    chk("R1 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset done", int'(done), 0);
    chk("R12 reset strobes", int'(fl_we | fl_re), 0);
    rst_n = 1'b1;
    // directed corners
    run(2'd1, 20'h12345, 8'h00, 8'h00, 0, 0, 0);
    run(2'd2, 20'h00010, 8'h5A, 8'h00, 0, 0, 0);
    run(2'd2, 20'h00011, 8'h3C, 8'h18, 2, 0, 1);   // R9 vpp wins
    run(2'd2, 20'h00012, 8'hC3, 8'h10, 1, 1, 2);   // R6 write error
    run(2'd3, 20'h30000, 8'h00, 8'h20, 1, 0, 0);   // R7 erase error
    run(2'd3, 20'h30000, 8'h00, 8'h28, 0, 0, 3);   // R9 vpp over erase
    run(2'd3, 20'h30000, 8'h00, 8'h10, 0, 0, 0);   // R7 bit4 ignored
    run(2'd2, 20'h00020, 8'h11, 8'h00, PM - 1, 0, 0); // R5 ready on last read
    run(2'd2, 20'h00021, 8'h22, 8'h10, PM, 0, 1);  // R8 timeout
    run(2'd3, 20'h40000, 8'h00, 8'h20, PM + 3, 0, 0); // R8 timeout erase
    run(2'd2, 20'h00022, 8'h33, 8'h00, 0, PM + 4, 2); // R10 clear times out
    run(2'd3, 20'h50000, 8'h00, 8'h08, 0, PM + 4, 0); // R10 keeps error
    run(2'd0, 20'hABCDE, 8'h00, 8'h00, 0, 0, 0);   // R11 unaligned
    cfg_dev = 8'hA3;
    run(2'd0, 20'h70001, 8'h00, 8'h00, 0, 0, 0);   // R11 mismatch
    cfg_dev = 8'hA2;
    // seeded random
    for (int k = 0; k < 40; k++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      cfg_mfr = ($urandom % 5 == 0) ? 8'h88 : 8'h89;
      run(op, AW'($urandom), 8'($urandom), 8'(($urandom % 8) << 3),
          int'($urandom % 9), int'($urandom % 3), int'($urandom % 4));
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule